// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block sits behind the boot-RAM address window of a paged flash device and interprets the 16-bit words the host writes there. Most words are single-cycle commands. One value requests a warm reset. Another fills a small identification area in the buffer. A third arms a two-write page load, and the load starts only when the second write is zero. A load goes to an external page loader through a request/done handshake, and it carries an array sector number built from the block and page start-address registers. After each load, the page register steps forward by four sectors.

The host also reaches three registers through a separate register port: the block start address, the page start address, and a start-buffer register that holds a buffer address and a sector count. While a load or an identification fill is in progress, boot-window writes are held off with a ready signal.

Top module: `boot_cmd_seq`

## Requirements
- R1: After reset, the register reads of block (select 0), page (select 1) and start-buffer (select 2) all return 0x0000, the load request is low and the boot-window ready is high.
- R2: An accepted boot-window write of 0x00F0 while idle raises the warm-reset request for exactly the one cycle that follows the accepting edge.
- R3: An accepted write of 0x00E0 arms the sequencer, and a following accepted write of 0x0000 raises the load request with a sector count of 4.
- R4: If the write that follows 0x00E0 is any value other than 0x0000, the sequence is disarmed without a load, and a later lone 0x0000 starts no load.
- R5: The load request and its sector number stay constant until the loader's done input is sampled high, and boot-window ready stays low for the whole time. A write offered during this time is taken only after the load completes.
- R6: On the edge where done is sampled during a load, the page register becomes (page + 4) mod 256.
- R7: An accepted write of 0x0090 makes exactly three buffer writes, to word addresses 0, 1 and 2 in that order. Their data is the manufacturer ID, the device ID and the low byte of the write-protect status, each with a zero upper byte.
- R8: The load sector number is (page & 3) + ((((page >> 2) & 0x3F) + (F << 6)) << 2). Here F is block & 0xFFF, ORed with the density mask (default 0x200) when block bit 15 is set.
- R9: A write to the start-buffer register stores data bits 11:8 as the buffer address and bits 1:0 as the count, with 0 meaning 4. A read returns (buffer address << 8) | ((count - 1) & 2).
- R10: Any other boot-window value while idle is ignored: no warm reset, no load, no buffer write, and the page register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_wr_vld | input | 1 | Boot-window write offered |
| boot_wr_data | input | 16 | Boot-window write value |
| boot_wr_rdy | output | 1 | Boot-window write can be accepted |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register write select: 0 block, 1 page, 2 start-buffer |
| reg_wdata | input | 16 | Register write data |
| rd_sel | input | 2 | Register read select, same encoding |
| rd_data | output | 16 | Register read data |
| mfr_id | input | 8 | Manufacturer ID byte |
| dev_id | input | 8 | Device ID byte |
| wp_status | input | 16 | Write-protect status word |
| warm_rst_req | output | 1 | One-cycle warm reset request |
| ld_req | output | 1 | Page load request |
| ld_sector | output | 20 | Sector number for the load |
| ld_count | output | 3 | Sectors to load (always 4) |
| ld_done | input | 1 | Loader finished |
| id_we | output | 1 | Identification buffer write strobe |
| id_addr | output | 2 | Identification buffer word address |
| id_wdata | output | 16 | Identification buffer write data |

## Verification
The hardest situation to create from the ports is a boot-window write that arrives while a load is still outstanding. That write must stay stalled, must not disturb the held sector, and must be accepted on the first idle cycle after done. The bench gets there by offering a reset-command write while it holds ld_done low for several cycles. It checks ready, the warm-reset output and the sector on each of those cycles, then releases done and looks for the late pulse. The page wrap at 256 is reached by preloading page 0xFE before a load.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LOAD  = 2'd2,
    ST_IDENT = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_BLOCK    = 2'd0,
    SEL_PAGE     = 2'd1,
    SEL_STARTBUF = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;

  localparam logic [15:0] CODE_WARM  = 16'h00F0;
  localparam logic [15:0] CODE_ARM   = 16'h00E0;
  localparam logic [15:0] CODE_IDENT = 16'h0090;
  localparam logic [15:0] CODE_GO    = 16'h0000;

endpackage

// File: rtl/boot_sector_map.sv
module boot_sector_map #(
  parameter int BLK_W        = 16,
  parameter int BLK_FIELD_W  = 12,
  parameter int PAGE_W       = 8,
  parameter int SEC_W        = BLK_FIELD_W + PAGE_W,
  parameter logic [BLK_FIELD_W-1:0] DENSITY_MASK = 12'h200
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic [PAGE_W-1:0] page,
  output logic [SEC_W-1:0]  sector
);

  localparam int SUB_W = 2;

  logic [BLK_FIELD_W-1:0] blk_field;
  logic [SEC_W-1:0]       page_hi;
  logic [SEC_W-1:0]       page_lo;
  logic [SEC_W-1:0]       unit_idx;

  always_comb begin
    blk_field = blk[BLK_FIELD_W-1:0];
    if (blk[BLK_W-1]) begin
      blk_field = blk_field | DENSITY_MASK;
    end
    page_hi  = SEC_W'(page[PAGE_W-1:SUB_W]);
    page_lo  = SEC_W'(page[SUB_W-1:0]);
    unit_idx = page_hi + (SEC_W'(blk_field) << (PAGE_W - SUB_W));
    sector   = page_lo + (unit_idx << SUB_W);
  end

endmodule

// File: rtl/boot_addr_regs.sv
module boot_addr_regs
  import boot_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PAGE_W  = 8,
  parameter int BUFA_W  = 4,
  parameter int BUFA_LSB = 8,
  parameter int PAGE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              page_adv,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] blk_q,
  output logic [PAGE_W-1:0] page_q
);

  localparam int CNT_W = 3;

  logic [DATA_W-1:0] blk_d;
  logic [PAGE_W-1:0] page_d;
  logic [BUFA_W-1:0] bufa_q, bufa_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              blk_en, page_en, sbuf_en;
  logic [CNT_W-1:0]  cnt_m1;

  always_comb begin
    blk_en  = reg_we && (reg_sel == SEL_BLOCK);
    page_en = (reg_we && (reg_sel == SEL_PAGE)) || page_adv;
    sbuf_en = reg_we && (reg_sel == SEL_STARTBUF);

    blk_d = reg_wdata;
    if (reg_we && (reg_sel == SEL_PAGE)) begin
      page_d = reg_wdata[PAGE_W-1:0];
    end else begin
      page_d = page_q + PAGE_W'(PAGE_STEP);
    end

    bufa_d = reg_wdata[BUFA_LSB +: BUFA_W];
    if (reg_wdata[1:0] == 2'd0) begin
      cnt_d = CNT_W'(4);
    end else begin
      cnt_d = CNT_W'(reg_wdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      page_q <= '0;
      bufa_q <= '0;
      cnt_q  <= CNT_W'(1);
    end else begin
      if (blk_en) begin
        blk_q <= blk_d;
      end
      if (page_en) begin
        page_q <= page_d;
      end
      if (sbuf_en) begin
        bufa_q <= bufa_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  always_comb begin
    cnt_m1 = cnt_q - CNT_W'(1);
    case (rd_sel)
      SEL_BLOCK:    rd_data = blk_q;
      SEL_PAGE:     rd_data = DATA_W'(page_q);
      SEL_STARTBUF: rd_data = (DATA_W'(bufa_q) << BUFA_LSB) |
                              DATA_W'(cnt_m1 & CNT_W'(2));
      default:      rd_data = '0;
    endcase
  end

  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_adv && !(reg_we && reg_sel == SEL_PAGE)) |=>
      (page_q == PAGE_W'($past(page_q) + PAGE_W'(PAGE_STEP))));

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(4)));

endmodule

// File: rtl/boot_cmd_fsm.sv
module boot_cmd_fsm
  import boot_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SEC_W    = 20,
  parameter int ID_WORDS = 3,
  parameter int ID_AW    = 2,
  parameter int LD_CNT   = 4,
  parameter int CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_rdy,
  input  logic [SEC_W-1:0]  sector_in,
  input  logic [7:0]        mfr_id,
  input  logic [7:0]        dev_id,
  input  logic [DATA_W-1:0] wp_status,
  output logic              warm_rst_req,
  output logic              ld_req,
  output logic [SEC_W-1:0]  ld_sector,
  output logic [CNT_W-1:0]  ld_count,
  input  logic              ld_done,
  output logic              page_adv,
  output logic              id_we,
  output logic [ID_AW-1:0]  id_addr,
  output logic [DATA_W-1:0] id_wdata
);

  seq_state_e       state_q, state_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             sec_en;
  logic             warm_q, warm_d;
  logic [ID_AW-1:0] idx_q, idx_d;
  logic             take;

  always_comb begin
    wr_rdy  = (state_q == ST_IDLE) || (state_q == ST_ARMED);
    take    = wr_vld && wr_rdy;
    state_d = state_q;
    sec_en  = 1'b0;
    sec_d   = sector_in;
    warm_d  = 1'b0;
    idx_d   = idx_q;
    page_adv = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take) begin
          if (wr_data == CODE_WARM) begin
            warm_d = 1'b1;
          end else if (wr_data == CODE_ARM) begin
            state_d = ST_ARMED;
          end else if (wr_data == CODE_IDENT) begin
            state_d = ST_IDENT;
            idx_d   = '0;
          end
        end
      end
      ST_ARMED: begin
        if (take) begin
          if (wr_data == CODE_GO) begin
            state_d = ST_LOAD;
            sec_en  = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_LOAD: begin
        if (ld_done) begin
          page_adv = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_IDENT: begin
        idx_d = idx_q + ID_AW'(1);
        if (idx_q == ID_AW'(ID_WORDS - 1)) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sec_q   <= '0;
      warm_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      warm_q  <= warm_d;
      idx_q   <= idx_d;
      if (sec_en) begin
        sec_q <= sec_d;
      end
    end
  end

  always_comb begin
    warm_rst_req = warm_q;
    ld_req       = (state_q == ST_LOAD);
    ld_sector    = sec_q;
    ld_count     = CNT_W'(LD_CNT);
    id_we        = (state_q == ST_IDENT);
    id_addr      = idx_q;
    case (idx_q)
      ID_AW'(0): id_wdata = {8'h00, mfr_id};
      ID_AW'(1): id_wdata = {8'h00, dev_id};
      ID_AW'(2): id_wdata = {8'h00, wp_status[7:0]};
      default:   id_wdata = '0;
    endcase
  end

  // R5
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_done) |=> ld_req);

  // R5
  sector_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_done) |=> $stable(ld_sector));

  // R5
  stall_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |-> !wr_rdy);

  // R7
  ident_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_we |-> (id_addr < ID_AW'(ID_WORDS)));

  // R7
  ident_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_we && id_addr != ID_AW'(ID_WORDS - 1)) |=>
      (id_we && id_addr == ID_AW'($past(id_addr) + ID_AW'(1))));

endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
  import boot_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BLK_FIELD_W = 12,
  parameter int PAGE_W      = 8,
  parameter int BUFA_W      = 4,
  parameter logic [BLK_FIELD_W-1:0] DENSITY_MASK = 12'h200,
  parameter int SEC_W       = BLK_FIELD_W + PAGE_W,
  parameter int CNT_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_wr_vld,
  input  logic [DATA_W-1:0] boot_wr_data,
  output logic              boot_wr_rdy,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [7:0]        mfr_id,
  input  logic [7:0]        dev_id,
  input  logic [DATA_W-1:0] wp_status,
  output logic              warm_rst_req,
  output logic              ld_req,
  output logic [SEC_W-1:0]  ld_sector,
  output logic [CNT_W-1:0]  ld_count,
  input  logic              ld_done,
  output logic              id_we,
  output logic [1:0]        id_addr,
  output logic [DATA_W-1:0] id_wdata
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [DATA_W-1:0]     blk_q;
  logic [PAGE_W-1:0]     page_q;
  logic [SEC_W-1:0]      sector;
  logic                  page_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  boot_addr_regs #(
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W),
    .BUFA_W (BUFA_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .page_adv  (page_adv),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .blk_q     (blk_q),
    .page_q    (page_q)
  );

  boot_sector_map #(
    .BLK_W        (DATA_W),
    .BLK_FIELD_W  (BLK_FIELD_W),
    .PAGE_W       (PAGE_W),
    .SEC_W        (SEC_W),
    .DENSITY_MASK (DENSITY_MASK)
  ) map_i (
    .blk    (blk_q),
    .page   (page_q),
    .sector (sector)
  );

  boot_cmd_fsm #(
    .DATA_W (DATA_W),
    .SEC_W  (SEC_W),
    .CNT_W  (CNT_W)
  ) fsm_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_vld       (boot_wr_vld),
    .wr_data      (boot_wr_data),
    .wr_rdy       (boot_wr_rdy),
    .sector_in    (sector),
    .mfr_id       (mfr_id),
    .dev_id       (dev_id),
    .wp_status    (wp_status),
    .warm_rst_req (warm_rst_req),
    .ld_req       (ld_req),
    .ld_sector    (ld_sector),
    .ld_count     (ld_count),
    .ld_done      (ld_done),
    .page_adv     (page_adv),
    .id_we        (id_we),
    .id_addr      (id_addr),
    .id_wdata     (id_wdata)
  );

endmodule

// File: tb/boot_cmd_seq_tb_top.sv
module boot_cmd_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_wr_vld = 1'b0;
  logic [15:0] boot_wr_data = '0;
  logic        boot_wr_rdy;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic [7:0]  mfr_id = 8'hEC;
  logic [7:0]  dev_id = 8'h48;
  logic [15:0] wp_status = 16'h1234;
  logic        warm_rst_req;
  logic        ld_req;
  logic [19:0] ld_sector;
  logic [2:0]  ld_count;
  logic        ld_done = 1'b0;
  logic        id_we;
  logic [1:0]  id_addr;
  logic [15:0] id_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int id_cnt = 0;
  int warm_cnt = 0;
  int ld_cnt = 0;
  logic [15:0] id_cap [3];
  logic [1:0]  id_ord [8];

  always #2.5 clk = ~clk;

  boot_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .boot_wr_vld(boot_wr_vld), .boot_wr_data(boot_wr_data), .boot_wr_rdy(boot_wr_rdy),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .mfr_id(mfr_id), .dev_id(dev_id), .wp_status(wp_status),
    .warm_rst_req(warm_rst_req), .ld_req(ld_req), .ld_sector(ld_sector),
    .ld_count(ld_count), .ld_done(ld_done),
    .id_we(id_we), .id_addr(id_addr), .id_wdata(id_wdata)
  );

  always @(posedge clk) begin
    if (id_we) begin
      if (id_addr < 2'd3) id_cap[id_addr] <= id_wdata;
      if (id_cnt < 8) id_ord[id_cnt] <= id_addr;
      id_cnt <= id_cnt + 1;
    end
    if (warm_rst_req) warm_cnt <= warm_cnt + 1;
    if (ld_req && !$past(ld_req)) ld_cnt <= ld_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_sector(input logic [15:0] b, input logic [7:0] p);
    int f;
    f = b & 16'h0FFF;
    if (b[15]) f = f | 12'h200;
    return 20'((p & 3) + ((((p >> 2) & 8'h3F) + (f << 6)) << 2));
  endfunction

  task automatic reg_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    rd_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic boot_write(input logic [15:0] d);
    @(negedge clk);
    boot_wr_vld = 1'b1; boot_wr_data = d;
    while (!boot_wr_rdy) @(negedge clk);
    @(negedge clk);
    boot_wr_vld = 1'b0;
  endtask

  task automatic finish_load(input int wait_cycles);
    repeat (wait_cycles) @(negedge clk);
    ld_done = 1'b1;
    @(negedge clk);
    ld_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    reg_read(2'd0, v); check("R1 block", v, 16'h0);
    reg_read(2'd1, v); check("R1 page", v, 16'h0);
    reg_read(2'd2, v); check("R1 startbuf", v, 16'h0);
    check("R1 ld_req", ld_req, 1'b0);
    check("R1 rdy", boot_wr_rdy, 1'b1);
  endtask

  task automatic t_warm;
    int w0;
    w0 = warm_cnt;
    @(negedge clk);
    boot_wr_vld = 1'b1; boot_wr_data = 16'h00F0;
    @(negedge clk);
    boot_wr_vld = 1'b0;
    check("R2 pulse high", warm_rst_req, 1'b1);
    @(negedge clk);
    check("R2 pulse low", warm_rst_req, 1'b0);
    check("R2 pulse count", warm_cnt - w0, 1);
  endtask

  task automatic t_load_basic;
    logic [15:0] v;
    reg_write(2'd0, 16'h0123);
    reg_write(2'd1, 16'h0035);
    boot_write(16'h00E0);
    boot_write(16'h0000);
    check("R3 ld_req", ld_req, 1'b1);
    check("R3 ld_count", ld_count, 3'd4);
    check("R8 sector plain", ld_sector, exp_sector(16'h0123, 8'h35));
    check("R8 sector literal", ld_sector, 20'h12335);
    finish_load(2);
    check("R6 ld_req dropped", ld_req, 1'b0);
    reg_read(2'd1, v); check("R6 page +4", v, 16'h0039);
  endtask

  task automatic t_density_wrap;
    logic [15:0] v;
    reg_write(2'd0, 16'h8005);
    reg_write(2'd1, 16'h00FE);
    boot_write(16'h00E0);
    boot_write(16'h0000);
    check("R8 sector density", ld_sector, exp_sector(16'h8005, 8'hFE));
    finish_load(1);
    reg_read(2'd1, v); check("R6 page wrap", v, 16'h0002);
  endtask

  task automatic t_stall;
    logic [19:0] s0;
    int w0;
    bit ok;
    reg_write(2'd0, 16'h0042);
    reg_write(2'd1, 16'h0010);
    boot_write(16'h00E0);
    boot_write(16'h0000);
    s0 = ld_sector;
    w0 = warm_cnt;
    ok = 1;
    @(negedge clk);
    boot_wr_vld = 1'b1; boot_wr_data = 16'h00F0;
    reg_wdata = 16'h0077; reg_sel = 2'd1; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (boot_wr_rdy !== 1'b0 || ld_req !== 1'b1 || ld_sector !== s0 || warm_rst_req !== 1'b0) ok = 0;
      @(negedge clk);
    end
    check("R5 held and stalled", ok, 1'b1);
    check("R5 sector value", s0, exp_sector(16'h0042, 8'h10));
    ld_done = 1'b1;
    @(negedge clk);
    ld_done = 1'b0;
    check("R5 rdy after done", boot_wr_rdy, 1'b1);
    @(negedge clk);
    boot_wr_vld = 1'b0;
    check("R5 late write taken", warm_rst_req, 1'b1);
    @(negedge clk);
    check("R5 single late pulse", warm_cnt - w0, 1);
  endtask

  task automatic t_disarm;
    int l0;
    logic [15:0] v;
    reg_write(2'd1, 16'h0020);
    l0 = ld_cnt;
    boot_write(16'h00E0);
    boot_write(16'h0005);
    repeat (2) @(negedge clk);
    check("R4 no load after disarm", ld_req, 1'b0);
    boot_write(16'h0000);
    repeat (2) @(negedge clk);
    check("R4 lone zero ignored", ld_cnt - l0, 0);
    reg_read(2'd1, v); check("R4 page untouched", v, 16'h0020);
  endtask

  task automatic t_ident;
    int c0;
    c0 = id_cnt;
    boot_write(16'h0090);
    repeat (4) @(negedge clk);
    check("R7 three writes", id_cnt - c0, 3);
    check("R7 order 0", id_ord[c0], 2'd0);
    check("R7 order 1", id_ord[c0+1], 2'd1);
    check("R7 order 2", id_ord[c0+2], 2'd2);
    check("R7 word0 mfr", id_cap[0], 16'h00EC);
    check("R7 word1 dev", id_cap[1], 16'h0048);
    check("R7 word2 wp", id_cap[2], 16'h0034);
  endtask

  task automatic t_startbuf;
    logic [15:0] v;
    reg_write(2'd2, 16'h0A00);
    reg_read(2'd2, v); check("R9 count0 means 4", v, 16'h0A02);
    reg_write(2'd2, 16'hF503);
    reg_read(2'd2, v); check("R9 count3", v, 16'h0502);
    reg_write(2'd2, 16'h0302);
    reg_read(2'd2, v); check("R9 count2", v, 16'h0300);
    reg_write(2'd2, 16'h0C01);
    reg_read(2'd2, v); check("R9 count1", v, 16'h0C00);
  endtask

  task automatic t_unknown;
    int w0, c0, l0;
    logic [15:0] v;
    reg_write(2'd1, 16'h0044);
    w0 = warm_cnt; c0 = id_cnt; l0 = ld_cnt;
    boot_write(16'h00A5);
    boot_write(16'h00F1);
    boot_write(16'h0000);
    repeat (3) @(negedge clk);
    check("R10 no warm", warm_cnt - w0, 0);
    check("R10 no id", id_cnt - c0, 0);
    check("R10 no load", ld_cnt - l0, 0);
    reg_read(2'd1, v); check("R10 page kept", v, 16'h0044);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_warm();
    t_load_basic();
    t_density_wrap();
    t_stall();
    t_disarm();
    t_ident();
    t_startbuf();
    t_unknown();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule